// File: doc/BRIEF.md
# General-Purpose I/O Port with Peripheral Direction Override

This block is an eight-pin general-purpose I/O port. Software reaches it through a small register bus. It can write the output data register, write the direction register, and read the pin levels back through a read-only input register. The pin levels reach that register through a two-flop synchroniser.

Peripheral modules elsewhere on the chip can take over three of the pins. Each of those pins has a set of claim enables. While any claim on a pin is active, the pin's direction is set by a fixed policy for that pin, not by the direction register:
- The output pin (bit 7) is always driven.
- The input pin (bit 6) is always released.
- The mixed pin (bit 5) is driven for most claimants. Its last claimant chooses the direction itself.

A claim never alters the stored direction bit. When every claim on a pin drops, the pin follows its stored bit again. When several claimants are active at once, the lowest-numbered enable wins.

Top module: `gpio_port`

## Requirements
- R1: After reset the data register and the direction register both read 0x00, and with no claims active every `pad_oe` bit is 0.
- R2: The data register (address 0) and the direction register (address 2) can be written with `bus_wr` at any time. Each reads back the last value written in the cycle after the write. A direction bit of 1 means output and 0 means input.
- R3: A write to the input register (address 1) changes neither the data register, nor the direction register, nor any pad output.
- R4: A read at address 1 returns the `pad_in` levels as they stood two rising clock edges earlier, whatever the direction bits are.
- R5: For every pin with no active claim, `pad_oe[i]` equals direction bit i and `pad_out[i]` equals data bit i.
- R6: While any bit of `out_pin_en` is set, pin 7 is an output. Its `pad_out` value is taken from `out_pin_dat` at the lowest set enable index.
- R7: While any bit of `in_pin_en` is set, pin 6 is an input (`pad_oe[6]` is 0).
- R8: For pin 5, the lowest set bit of `mix_pin_en` wins. Indices 0 and 1 force an output with `pad_out[5]` taken from `mix_pin_dat` at that index. Index 2, when it wins, gives `pad_oe[5] = mix_pin_dir` and `pad_out[5] = mix_pin_dat[2]`.
- R9: Claims never change the stored direction bits. Once a pin's claims are all released, its `pad_oe` follows the direction register again.
- R10: A read at address 3 returns zero. A write to address 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | 2 | Register address: 0 data, 1 input, 2 direction, 3 unmapped |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pad_in | input | 8 | Asynchronous pin levels from the pads |
| pad_out | output | 8 | Value driven onto each pad |
| pad_oe | output | 8 | Pad output enable, 1 = drive |
| out_pin_en | input | 3 | Claim enables for pin 7 (forced output) |
| out_pin_dat | input | 3 | Claimant output data for pin 7 |
| in_pin_en | input | 3 | Claim enables for pin 6 (forced input) |
| mix_pin_en | input | 3 | Claim enables for pin 5 |
| mix_pin_dat | input | 3 | Claimant output data for pin 5 |
| mix_pin_dir | input | 1 | Direction chosen by claimant 2 of pin 5, 1 = output |

## Verification
The checker assumes the claim inputs and `mix_pin_dir` are synchronous to `clk` and hold a defined level. It also assumes `rst_n` is low at the first edge. The override properties compare `pad_oe` in the same cycle as the enables. This is valid only because the stimulus changes the claim inputs on the falling edge, never near the rising one. `pad_in` is the only input treated as asynchronous. The bench waits two full edges after changing it before reading the input register back.

// File: rtl/gpio_port_pkg.sv
// Package for the GPIO port.
// Holds the register address map and the per-pin claim policy type.
// Assumes a two-bit register address space.
package gpio_port_pkg;

    localparam int REG_AW = 2;

    localparam logic [REG_AW-1:0] ADDR_DATA = 2'd0;
    localparam logic [REG_AW-1:0] ADDR_PINS = 2'd1;
    localparam logic [REG_AW-1:0] ADDR_DIR  = 2'd2;

    // How an active claim on a pin sets its direction.
    typedef enum logic [1:0] {
        CLAIM_NONE  = 2'd0,
        CLAIM_OUT   = 2'd1,
        CLAIM_IN    = 2'd2,
        CLAIM_MIXED = 2'd3
    } claim_policy_e;

endpackage

// File: rtl/gpio_sync.sv
// Multi-stage synchroniser for the pad input levels.
// Each bit passes through STAGES flops before it is used.
// Assumes pad_in is asynchronous to clk, and that bits may be sampled
// independently of one another.
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the pad levels through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_regs.sv
// Register file for the GPIO port.
// Holds the data and direction registers and the combinational read mux.
// Assumes one write strobe per cycle. The input register has no storage
// here: it is the synchronised pin vector.
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [REG_AW-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [WIDTH-1:0]  pins_sync,
    output logic [WIDTH-1:0]  rdata,
    output logic [WIDTH-1:0]  data_q,
    output logic [WIDTH-1:0]  dir_q
);

    // Update the data register on a write to its address.
    always_ff @(posedge clk) begin
        if (!rst_n)                         data_q <= '0;
        else if (wr && addr == ADDR_DATA)   data_q <= wdata;
    end

    // Update the direction register on a write to its address.
    always_ff @(posedge clk) begin
        if (!rst_n)                         dir_q <= '0;
        else if (wr && addr == ADDR_DIR)    dir_q <= wdata;
    end

    // Select read data by address; unmapped addresses read as zero.
    always_comb begin
        case (addr)
            ADDR_DATA: rdata = data_q;
            ADDR_PINS: rdata = pins_sync;
            ADDR_DIR:  rdata = dir_q;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_pin_mux.sv
// Override multiplexer for one pin.
// Picks the lowest-numbered active claim. It then applies the pin's fixed
// policy to produce the pad output enable and the pad output value.
// Assumes every claim input is synchronous to clk. With no claim active,
// the pin follows the register values.
module gpio_pin_mux
    import gpio_port_pkg::*;
#(
    parameter int            NSRC   = 3,
    parameter claim_policy_e POLICY = CLAIM_NONE
) (
    input  logic [NSRC-1:0] src_en,
    input  logic [NSRC-1:0] src_dat,
    input  logic            src_dir,
    input  logic            reg_dir,
    input  logic            reg_dat,
    output logic            pin_oe,
    output logic            pin_out
);

    localparam int            IW   = (NSRC > 1) ? $clog2(NSRC) : 1;
    localparam logic [IW-1:0] LAST = IW'(NSRC - 1);

    logic [IW-1:0] win;
    logic          any;

    // Find the lowest-numbered active claim.
    always_comb begin
        win = '0;
        any = 1'b0;
        for (int k = NSRC - 1; k >= 0; k--) begin
            if (src_en[k]) begin
                win = IW'(k);
                any = 1'b1;
            end
        end
    end

    // Apply the pin's claim policy, or fall back to the registers.
    always_comb begin
        pin_oe  = reg_dir;
        pin_out = reg_dat;
        if (any) begin
            case (POLICY)
                CLAIM_OUT: begin
                    pin_oe  = 1'b1;
                    pin_out = src_dat[win];
                end
                CLAIM_IN: begin
                    pin_oe  = 1'b0;
                end
                CLAIM_MIXED: begin
                    pin_oe  = (win == LAST) ? src_dir : 1'b1;
                    pin_out = src_dat[win];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_port.sv
// Top level of the GPIO port with peripheral direction override.
// Joins the synchroniser, the register file and one override mux per pin.
// Assumes OUT_PIN, IN_PIN and MIX_PIN are distinct and below WIDTH.
// Pins with no claim policy get their claim inputs tied off.
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter int NSRC    = 3,
    parameter int OUT_PIN = 7,
    parameter int IN_PIN  = 6,
    parameter int MIX_PIN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe,
    input  logic [NSRC-1:0]   out_pin_en,
    input  logic [NSRC-1:0]   out_pin_dat,
    input  logic [NSRC-1:0]   in_pin_en,
    input  logic [NSRC-1:0]   mix_pin_en,
    input  logic [NSRC-1:0]   mix_pin_dat,
    input  logic              mix_pin_dir
);

    logic [WIDTH-1:0] pins_sync;
    logic [WIDTH-1:0] reg_data;
    logic [WIDTH-1:0] reg_dir;

    gpio_sync #(.WIDTH(WIDTH), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pins_sync)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .pins_sync (pins_sync),
        .rdata     (bus_rdata),
        .data_q    (reg_data),
        .dir_q     (reg_dir)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        if (i == OUT_PIN) begin : g_out
            gpio_pin_mux #(.NSRC(NSRC), .POLICY(CLAIM_OUT)) u_mux (
                .src_en  (out_pin_en),
                .src_dat (out_pin_dat),
                .src_dir (1'b0),
                .reg_dir (reg_dir[i]),
                .reg_dat (reg_data[i]),
                .pin_oe  (pad_oe[i]),
                .pin_out (pad_out[i])
            );
        end else if (i == IN_PIN) begin : g_in
            gpio_pin_mux #(.NSRC(NSRC), .POLICY(CLAIM_IN)) u_mux (
                .src_en  (in_pin_en),
                .src_dat ({NSRC{1'b0}}),
                .src_dir (1'b0),
                .reg_dir (reg_dir[i]),
                .reg_dat (reg_data[i]),
                .pin_oe  (pad_oe[i]),
                .pin_out (pad_out[i])
            );
        end else if (i == MIX_PIN) begin : g_mix
            gpio_pin_mux #(.NSRC(NSRC), .POLICY(CLAIM_MIXED)) u_mux (
                .src_en  (mix_pin_en),
                .src_dat (mix_pin_dat),
                .src_dir (mix_pin_dir),
                .reg_dir (reg_dir[i]),
                .reg_dat (reg_data[i]),
                .pin_oe  (pad_oe[i]),
                .pin_out (pad_out[i])
            );
        end else begin : g_plain
            gpio_pin_mux #(.NSRC(NSRC), .POLICY(CLAIM_NONE)) u_mux (
                .src_en  ({NSRC{1'b0}}),
                .src_dat ({NSRC{1'b0}}),
                .src_dir (1'b0),
                .reg_dir (reg_dir[i]),
                .reg_dat (reg_data[i]),
                .pin_oe  (pad_oe[i]),
                .pin_out (pad_out[i])
            );
        end
    end

endmodule

// File: rtl/gpio_port_chk.sv
// Assertion checker for gpio_port, attached with the bind statement below.
// Assumes claim inputs are synchronous to clk and that rst_n is low at the
// first clock edge.
module gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter int NSRC    = 3,
    parameter int OUT_PIN = 7,
    parameter int IN_PIN  = 6,
    parameter int MIX_PIN = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [REG_AW-1:0] bus_addr,
    input logic [NSRC-1:0]   out_pin_en,
    input logic [NSRC-1:0]   in_pin_en,
    input logic [WIDTH-1:0]  pad_oe,
    input logic [WIDTH-1:0]  pad_out,
    input logic [WIDTH-1:0]  data_q,
    input logic [WIDTH-1:0]  dir_q
);

    localparam logic [WIDTH-1:0] CLAIM_MASK =
        (WIDTH'(1) << OUT_PIN) | (WIDTH'(1) << IN_PIN) | (WIDTH'(1) << MIX_PIN);
    localparam logic [WIDTH-1:0] FREE_MASK = ~CLAIM_MASK;

    // R1: unclaimed pins are inputs right after a reset cycle.
    a_r1_reset_inputs: assert property (@(posedge clk)
        !rst_n |=> ((pad_oe & FREE_MASK) == '0));

    // R3: a write to the input register leaves both stored registers unchanged.
    a_r3_pins_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_PINS) |=> ($stable(data_q) && $stable(dir_q)));

    // R5: unclaimed pins follow the registers.
    a_r5_free_follow: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & FREE_MASK) == (dir_q & FREE_MASK)) &&
        ((pad_out & FREE_MASK) == (data_q & FREE_MASK)));

    // R6: a claim on the output pin drives it.
    a_r6_out_pin_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (|out_pin_en) |-> pad_oe[OUT_PIN]);

    // R7: a claim on the input pin releases it.
    a_r7_in_pin_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (|in_pin_en) |-> !pad_oe[IN_PIN]);

    // R9: the direction register moves only on a write to its own address.
    a_r9_dir_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ADDR_DIR) |=> $stable(dir_q));

    // R10: a write to the unmapped address changes no register.
    a_r10_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd3) |=> ($stable(data_q) && $stable(dir_q)));

endmodule

bind gpio_port gpio_port_chk #(
    .WIDTH   (WIDTH),
    .NSRC    (NSRC),
    .OUT_PIN (OUT_PIN),
    .IN_PIN  (IN_PIN),
    .MIX_PIN (MIX_PIN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .out_pin_en (out_pin_en),
    .in_pin_en  (in_pin_en),
    .pad_oe     (pad_oe),
    .pad_out    (pad_out),
    .data_q     (reg_data),
    .dir_q      (reg_dir)
);

// File: tb/sim_gpio_port.sv
// Self-checking bench for gpio_port.
// Sweeps register values, pin levels and every claim combination.
module sim_gpio_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = 8'd0;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;
    logic [2:0] out_pin_en = 3'd0;
    logic [2:0] out_pin_dat = 3'd0;
    logic [2:0] in_pin_en = 3'd0;
    logic [2:0] mix_pin_en = 3'd0;
    logic [2:0] mix_pin_dat = 3'd0;
    logic       mix_pin_dir = 1'b0;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .out_pin_en(out_pin_en),
        .out_pin_dat(out_pin_dat), .in_pin_en(in_pin_en),
        .mix_pin_en(mix_pin_en), .mix_pin_dat(mix_pin_dat),
        .mix_pin_dir(mix_pin_dir)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        logic [7:0] saved_dir;
        logic [7:0] saved_dat;
        logic       e_oe;
        logic       e_out;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        bus_read(2'd0, rd); check("R1 data", rd, 8'h00);
        bus_read(2'd2, rd); check("R1 dir", rd, 8'h00);
        check("R1 pad_oe", pad_oe, 8'h00);

        // R2/R5: sweep every direction and data value, no claims
        for (int v = 0; v < 256; v++) begin
            bus_write(2'd2, 8'(v));
            bus_write(2'd0, 8'(255 - v));
            bus_read(2'd2, rd); check("R2 dir readback", rd, 8'(v));
            bus_read(2'd0, rd); check("R2 data readback", rd, 8'(255 - v));
            check("R5 pad_oe", pad_oe, 8'(v));
            check("R5 pad_out", pad_out, 8'(255 - v));
        end

        // R4: pin levels read back after two edges, for both directions
        for (int d = 0; d < 2; d++) begin
            bus_write(2'd2, d ? 8'hFF : 8'h00);
            for (int v = 0; v < 256; v++) begin
                @(negedge clk);
                pad_in = 8'(v * 37 + d);
                @(posedge clk); @(posedge clk); @(negedge clk);
                bus_read(2'd1, rd);
                check("R4 pins", rd, 8'(v * 37 + d));
            end
        end

        // R3: a write to the input register changes nothing
        bus_write(2'd2, 8'h3C);
        bus_write(2'd0, 8'hA5);
        bus_write(2'd1, 8'h5A);
        bus_read(2'd0, rd); check("R3 data", rd, 8'hA5);
        bus_read(2'd2, rd); check("R3 dir", rd, 8'h3C);
        check("R3 pad_oe", pad_oe, 8'h3C);
        check("R3 pad_out", pad_out, 8'hA5);

        // R10: the unmapped address reads zero and ignores writes
        bus_write(2'd3, 8'hFF);
        bus_read(2'd3, rd); check("R10 read", rd, 8'h00);
        bus_read(2'd0, rd); check("R10 data", rd, 8'hA5);
        bus_read(2'd2, rd); check("R10 dir", rd, 8'h3C);

        // R6/R7/R8/R9: claim sweeps with register bits at both levels
        for (int r = 0; r < 2; r++) begin
            saved_dir = r ? 8'hFF : 8'h00;
            saved_dat = r ? 8'h00 : 8'hFF;
            bus_write(2'd2, saved_dir);
            bus_write(2'd0, saved_dat);
            for (int c = 0; c < 64; c++) begin
                @(negedge clk);
                out_pin_en = 3'(c); out_pin_dat = 3'(c >> 3);
                #1;
                if (c[0])      begin e_oe = 1'b1; e_out = out_pin_dat[0]; end
                else if (c[1]) begin e_oe = 1'b1; e_out = out_pin_dat[1]; end
                else if (c[2]) begin e_oe = 1'b1; e_out = out_pin_dat[2]; end
                else           begin e_oe = saved_dir[7]; e_out = saved_dat[7]; end
                check("R6 oe7", {7'd0, pad_oe[7]}, {7'd0, e_oe});
                check("R6 out7", {7'd0, pad_out[7]}, {7'd0, e_out});
            end
            for (int c = 0; c < 8; c++) begin
                @(negedge clk);
                in_pin_en = 3'(c);
                #1;
                e_oe = (c != 0) ? 1'b0 : saved_dir[6];
                check("R7 oe6", {7'd0, pad_oe[6]}, {7'd0, e_oe});
            end
            for (int c = 0; c < 128; c++) begin
                @(negedge clk);
                mix_pin_en = 3'(c); mix_pin_dat = 3'(c >> 3); mix_pin_dir = c[6];
                #1;
                if (c[0])      begin e_oe = 1'b1; e_out = mix_pin_dat[0]; end
                else if (c[1]) begin e_oe = 1'b1; e_out = mix_pin_dat[1]; end
                else if (c[2]) begin e_oe = mix_pin_dir; e_out = mix_pin_dat[2]; end
                else           begin e_oe = saved_dir[5]; e_out = saved_dat[5]; end
                check("R8 oe5", {7'd0, pad_oe[5]}, {7'd0, e_oe});
                check("R8 out5", {7'd0, pad_out[5]}, {7'd0, e_out});
            end
            // R9: all claims held, then released
            @(negedge clk);
            out_pin_en = 3'b111; in_pin_en = 3'b111; mix_pin_en = 3'b111;
            @(negedge clk);
            bus_read(2'd2, rd); check("R9 dir kept under claim", rd, saved_dir);
            out_pin_en = 3'd0; in_pin_en = 3'd0; mix_pin_en = 3'd0;
            #1;
            check("R9 release oe", pad_oe, saved_dir);
            check("R9 release out", pad_out, saved_dat);
        end

        finish_run();
    end

endmodule